// File: doc/BRIEF.md
# Frame injection word sequencer

This block converts a byte-serial outbound frame, together with a fixed-length header, into the exact series of 32-bit writes that a switch CPU injection queue expects. Each write carries a flag that tells whether it targets the queue's control register or its data register. A frame begins only when the queue reports that it is ready. If the queue is not ready, the frame is turned away with a busy strobe so that the source can retry it later.

An accepted frame is emitted in a fixed order. First comes a start control word, then the header words, then the payload packed four bytes per word. Zero words follow until the minimum frame size is reached, then an end control word that reports the valid bytes in the last word, and finally a zero placeholder for the CRC. While the CRC word is on the port, the queue's watermark flag is sampled. If that flag is set, the sequencer holds off new frames for a programmable number of cycles. When that time ends, it pulses a counter clear, but only if the watermark is still set.

Top module: `inj_word_seq`

## Requirements
- R1: After reset, `wr_en`, `in_ready`, `busy` and `wm_clr` are all low.
- R2: When a first byte is offered while the sequencer is idle and not holding off, and `q_ready` is low, `busy` is high in that cycle. No write is issued and no byte is taken.
- R3: The first write of a frame is a control write (`wr_ctrl`=1) with bit 0 (start) = 1, bit 1 (end) = 0, bits 9:8 (gap) = 1 and all other bits 0. The next `HDR_WORDS` writes are data writes carrying `hdr_in` word 0 first, where word k is `hdr_in[32k+31:32k]`.
- R4: The payload is sent as ceil(`in_len`/4) data writes. Frame byte i sits in word i/4 at bits 8*(i%4)+7 : 8*(i%4), and unused lanes of the last word are zero.
- R5: When fewer than 15 payload words were written, zero data words are appended until 15 words in total have been written.
- R6: After the padding comes a control write with bit 1 = 1, bit 0 = 0, bits 9:8 = 1, and bits 5:4 = `in_len` mod 4, or 0 when `in_len` < 60.
- R7: The write right after the end control write is an all-zero data write.
- R8: `wm_flag` is sampled in the cycle in which the CRC word is presented. If it is set, the next start write appears `TIMEOUT_US*CLK_MHZ`+2 cycles after that cycle, and otherwise 2 cycles after it, provided the next frame is already waiting. While the hold-off lasts, `in_ready` and `busy` stay low.
- R9: When the hold-off ends, `wm_clr` is high for exactly one cycle if `wm_flag` was set in the last hold-off cycle. Otherwise it stays low.
- R10: Bytes are taken only while `in_ready` is high, which is only during the payload phase. Idle cycles in the byte stream (`in_valid` low) do not change the write sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte stream valid |
| in_ready | output | 1 | Byte taken at this edge when high with in_valid |
| in_data | input | 8 | Frame byte |
| in_first | input | 1 | Marks the first byte of a frame |
| in_last | input | 1 | Marks the last byte of a frame |
| in_len | input | LEN_W | Frame length in bytes, held with the first byte |
| hdr_in | input | 32*HDR_WORDS | Header words, captured at frame start |
| q_ready | input | 1 | Injection queue ready |
| busy | output | 1 | Frame refused because the queue is not ready |
| wr_en | output | 1 | Write strobe |
| wr_ctrl | output | 1 | 1 = control register write, 0 = data write |
| wr_data | output | 32 | Write value |
| wm_flag | input | 1 | Queue watermark reached |
| wm_clr | output | 1 | Watermark counter clear pulse |

## Verification
The bench builds the block with three header words, a 9-bit length and a hold-off of 10 cycles (`CLK_MHZ`=2, `TIMEOUT_US`=5). With these values the hold-off expiry, the cycle gap to the next start write and the conditional clear pulse can all be checked exactly, within a few dozen cycles. The short length field still covers frames well past the 60-byte minimum, so lengths 1, 4, 59, 60, 61, 63, 64 and random lengths up to 200 exercise every padding and valid-byte case.

// File: rtl/inj_pkg.sv
package inj_pkg;

    localparam int unsigned WORD_W          = 32;
    localparam int unsigned MIN_FRAME_BYTES = 60;
    localparam int unsigned MIN_FRAME_WORDS = MIN_FRAME_BYTES / 4;
    localparam logic [1:0]  GAP_SIZE        = 2'd1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_PAY,
        ST_PAD,
        ST_EOF,
        ST_CRC,
        ST_WM
    } seq_state_e;

    typedef struct packed {
        logic              en;
        logic              ctrl;
        logic [WORD_W-1:0] data;
    } inj_write_t;

    // Control register image: bit0 start, bit1 end, 5:4 valid bytes, 9:8 gap
    function automatic logic [WORD_W-1:0] make_ctrl(input logic sof,
                                                    input logic eof,
                                                    input logic [1:0] vld);
        logic [WORD_W-1:0] w;
        w      = '0;
        w[0]   = sof;
        w[1]   = eof;
        w[5:4] = vld;
        w[9:8] = GAP_SIZE;
        return w;
    endfunction

    function automatic logic [1:0] vld_for_len(input logic [31:0] len);
        return (len < MIN_FRAME_BYTES) ? 2'd0 : len[1:0];
    endfunction

endpackage

// File: rtl/inj_byte_packer.sv
module inj_byte_packer
    import inj_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [7:0]        byte_in,
    input  logic              last_in,
    output logic [WORD_W-1:0] word_out,
    output logic              word_done
);

    logic [1:0]      lane;
    logic [3:0][7:0] acc;
    logic [3:0][7:0] word_v;

    always_comb begin
        for (int k = 0; k < 4; k++) begin
            if (k < int'(lane))
                word_v[k] = acc[k];
            else if (k == int'(lane))
                word_v[k] = byte_in;
            else
                word_v[k] = 8'h00;
        end
    end

    assign word_out  = word_v;
    assign word_done = take && ((lane == 2'd3) || last_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            lane <= 2'd0;
            acc  <= '0;
        end else if (take) begin
            if (word_done) begin
                lane <= 2'd0;
                acc  <= '0;
            end else begin
                acc[lane] <= byte_in;
                lane      <= lane + 2'd1;
            end
        end
    end

endmodule

// File: rtl/inj_holdoff.sv
module inj_holdoff #(
    parameter int unsigned TIMEOUT_CYC = 12500
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic wm_flag,
    output logic hold,
    output logic wm_clr
);

    localparam int unsigned CNT_W = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(TIMEOUT_CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            hold   <= 1'b0;
            wm_clr <= 1'b0;
        end else begin
            wm_clr <= 1'b0;
            if (hold) begin
                if (cnt == '0) begin
                    hold   <= 1'b0;
                    wm_clr <= wm_flag;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end else if (arm) begin
                hold <= 1'b1;
                cnt  <= CNT_INIT;
            end
        end
    end

endmodule

// File: rtl/inj_word_seq.sv
module inj_word_seq
    import inj_pkg::*;
#(
    parameter int unsigned HDR_WORDS  = 9,
    parameter int unsigned LEN_W      = 14,
    parameter int unsigned CLK_MHZ    = 250,
    parameter int unsigned TIMEOUT_US = 50
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [7:0]              in_data,
    input  logic                    in_first,
    input  logic                    in_last,
    input  logic [LEN_W-1:0]        in_len,
    input  logic [32*HDR_WORDS-1:0] hdr_in,
    input  logic                    q_ready,
    output logic                    busy,
    output logic                    wr_en,
    output logic                    wr_ctrl,
    output logic [31:0]             wr_data,
    input  logic                    wm_flag,
    output logic                    wm_clr
);

    localparam int unsigned TIMEOUT_CYC = CLK_MHZ * TIMEOUT_US;
    localparam int unsigned HIDX_W      = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1;
    localparam int unsigned WCNT_W      = LEN_W;
    localparam logic [HIDX_W-1:0] HIDX_LAST = HIDX_W'(HDR_WORDS - 1);
    localparam logic [WCNT_W-1:0] MIN_W     = WCNT_W'(MIN_FRAME_WORDS);

    seq_state_e  state;
    inj_write_t  wr_q;
    logic [HIDX_W-1:0]   hidx;
    logic [WCNT_W-1:0]   words;
    logic [WCNT_W-1:0]   words_nx;
    logic [LEN_W-1:0]    len_q;
    logic [HDR_WORDS-1:0][WORD_W-1:0] hdr_q;

    logic hold_active;
    logic start_ok;
    logic arm_hold;
    logic take;
    logic [WORD_W-1:0] pack_word;
    logic pack_done;

    assign start_ok = (state == ST_IDLE) && !hold_active && in_valid && in_first && q_ready;
    assign busy     = (state == ST_IDLE) && !hold_active && in_valid && in_first && !q_ready;
    assign in_ready = (state == ST_PAY);
    assign take     = in_ready && in_valid;
    assign arm_hold = (state == ST_WM) && wm_flag;
    assign words_nx = words + 1'b1;

    assign wr_en   = wr_q.en;
    assign wr_ctrl = wr_q.ctrl;
    assign wr_data = wr_q.data;

    // Header capture, one register per header word
    for (genvar g = 0; g < int'(HDR_WORDS); g++) begin : g_hdr
        always_ff @(posedge clk) begin
            if (rst)
                hdr_q[g] <= '0;
            else if (start_ok)
                hdr_q[g] <= hdr_in[g*32 +: 32];
        end
    end

    inj_byte_packer u_pack (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .byte_in   (in_data),
        .last_in   (in_last),
        .word_out  (pack_word),
        .word_done (pack_done)
    );

    inj_holdoff #(
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_hold (
        .clk     (clk),
        .rst     (rst),
        .arm     (arm_hold),
        .wm_flag (wm_flag),
        .hold    (hold_active),
        .wm_clr  (wm_clr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            wr_q  <= '0;
            hidx  <= '0;
            words <= '0;
            len_q <= '0;
        end else begin
            wr_q <= '0;
            unique case (state)
                ST_IDLE: begin
                    if (start_ok) begin
                        len_q     <= in_len;
                        hidx      <= '0;
                        words     <= '0;
                        wr_q.en   <= 1'b1;
                        wr_q.ctrl <= 1'b1;
                        wr_q.data <= make_ctrl(1'b1, 1'b0, 2'd0);
                        state     <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    wr_q.en   <= 1'b1;
                    wr_q.data <= hdr_q[hidx];
                    if (hidx == HIDX_LAST)
                        state <= ST_PAY;
                    else
                        hidx <= hidx + 1'b1;
                end
                ST_PAY: begin
                    if (pack_done) begin
                        wr_q.en   <= 1'b1;
                        wr_q.data <= pack_word;
                        words     <= words_nx;
                        if (in_last)
                            state <= (words_nx < MIN_W) ? ST_PAD : ST_EOF;
                    end
                end
                ST_PAD: begin
                    wr_q.en <= 1'b1;
                    words   <= words_nx;
                    if (words_nx >= MIN_W)
                        state <= ST_EOF;
                end
                ST_EOF: begin
                    wr_q.en   <= 1'b1;
                    wr_q.ctrl <= 1'b1;
                    wr_q.data <= make_ctrl(1'b0, 1'b1, vld_for_len(32'(len_q)));
                    state     <= ST_CRC;
                end
                ST_CRC: begin
                    wr_q.en <= 1'b1;
                    state   <= ST_WM;
                end
                ST_WM: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/inj_seq_chk.sv
module inj_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic        wr_ctrl,
    input logic [31:0] wr_data,
    input logic        busy,
    input logic        in_ready,
    input logic        hold,
    input logic        wm_flag,
    input logic        wm_clr
);

    p_refuse_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        busy |=> !wr_en);

    p_refuse_no_take_r2: assert property (@(posedge clk) disable iff (rst)
        busy |-> !in_ready);

    p_start_then_data_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ctrl && wr_data[0]) |=> (wr_en && !wr_ctrl));

    p_ctrl_gap_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ctrl) |-> (wr_data[9:8] == 2'd1 && (wr_data[0] != wr_data[1])));

    p_crc_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ctrl && wr_data[1]) |=> (wr_en && !wr_ctrl && wr_data == 32'd0));

    p_hold_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        hold |-> (!in_ready && !busy && !wr_en));

    p_clr_on_expiry_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(hold) |-> (wm_clr == $past(wm_flag)));

    p_clr_single_r9: assert property (@(posedge clk) disable iff (rst)
        wm_clr |=> !wm_clr);

    p_clr_only_after_hold_r9: assert property (@(posedge clk) disable iff (rst)
        wm_clr |-> $fell(hold));

endmodule

bind inj_word_seq inj_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_ctrl  (wr_ctrl),
    .wr_data  (wr_data),
    .busy     (busy),
    .in_ready (in_ready),
    .hold     (hold_active),
    .wm_flag  (wm_flag),
    .wm_clr   (wm_clr)
);

// File: tb/inj_word_seq_tb.sv
module inj_word_seq_tb;

    localparam int HDR_WORDS  = 3;
    localparam int LEN_W      = 9;
    localparam int CLK_MHZ    = 2;
    localparam int TIMEOUT_US = 5;
    localparam int T_CYC      = CLK_MHZ * TIMEOUT_US;
    localparam int CAP_MAX    = 4096;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    in_valid = 1'b0;
    logic                    in_ready;
    logic [7:0]              in_data = 8'h00;
    logic                    in_first = 1'b0;
    logic                    in_last = 1'b0;
    logic [LEN_W-1:0]        in_len = '0;
    logic [32*HDR_WORDS-1:0] hdr_in = '0;
    logic                    q_ready = 1'b1;
    logic                    busy;
    logic                    wr_en;
    logic                    wr_ctrl;
    logic [31:0]             wr_data;
    logic                    wm_flag = 1'b0;
    logic                    wm_clr;

    always #2 clk = ~clk;

    inj_word_seq #(
        .HDR_WORDS  (HDR_WORDS),
        .LEN_W      (LEN_W),
        .CLK_MHZ    (CLK_MHZ),
        .TIMEOUT_US (TIMEOUT_US)
    ) u_dut (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .in_first (in_first),
        .in_last  (in_last),
        .in_len   (in_len),
        .hdr_in   (hdr_in),
        .q_ready  (q_ready),
        .busy     (busy),
        .wr_en    (wr_en),
        .wr_ctrl  (wr_ctrl),
        .wr_data  (wr_data),
        .wm_flag  (wm_flag),
        .wm_clr   (wm_clr)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic        cap_ctrl [CAP_MAX];
    logic [31:0] cap_data [CAP_MAX];
    int          cap_cyc  [CAP_MAX];
    int          cap_n    = 0;
    int          clr_cnt  = 0;

    logic        exp_ctrl [256];
    logic [31:0] exp_data [256];
    int          exp_n;
    logic [7:0]  fb [512];

    int prev_crc_cyc = -1;
    bit prev_wm      = 1'b0;
    bit prev_late    = 1'b0;
    int clr_mark     = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (wr_en === 1'b1 && cap_n < CAP_MAX) begin
            cap_ctrl[cap_n] = wr_ctrl;
            cap_data[cap_n] = wr_data;
            cap_cyc[cap_n]  = cyc;
            cap_n           = cap_n + 1;
        end
        if (wm_clr === 1'b1) clr_cnt = clr_cnt + 1;
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: run hung, actual cycle %0d expected below 150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ctrl_img(input bit sof, input bit eof, input int vld);
        logic [31:0] w = 32'd0;
        w[0]   = sof;
        w[1]   = eof;
        w[5:4] = vld[1:0];
        w[9:8] = 2'd1;
        return w;
    endfunction

    task automatic push_exp(input logic c, input logic [31:0] d);
        exp_ctrl[exp_n] = c;
        exp_data[exp_n] = d;
        exp_n++;
    endtask

    task automatic build_expected(input int len);
        int nw;
        exp_n = 0;
        push_exp(1'b1, ctrl_img(1, 0, 0));
        for (int h = 0; h < HDR_WORDS; h++) push_exp(1'b0, hdr_in[h*32 +: 32]);
        nw = (len + 3) / 4;
        for (int w = 0; w < nw; w++) begin
            logic [31:0] d = 32'd0;
            for (int k = 0; k < 4; k++)
                if (4*w + k < len) d[8*k +: 8] = fb[4*w + k];
            push_exp(1'b0, d);
        end
        for (int w = nw; w < 15; w++) push_exp(1'b0, 32'd0);
        push_exp(1'b1, ctrl_img(0, 1, (len < 60) ? 0 : len % 4));
        push_exp(1'b0, 32'd0);
    endtask

    // R10: bytes advance only on cycles where in_ready is high
    task automatic drive_frame(input int len, input bit gaps);
        for (int i = 0; i < len; i++) begin
            if (gaps && i > 0 && ($urandom % 4 == 0)) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_data  = fb[i];
            in_first = (i == 0);
            in_last  = (i == len - 1);
            in_len   = LEN_W'(len);
            #1;
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_first = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic run_frame(input int len, input bit wm_crc, input bit wm_late,
                             input bit gaps, input bit check_gap);
        int base;
        for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
        for (int h = 0; h < HDR_WORDS; h++) hdr_in[h*32 +: 32] = $urandom;
        q_ready = 1'b1;
        build_expected(len);
        base = cap_n;
        fork
            drive_frame(len, gaps);
            begin
                wait (cap_n > base);
                wm_flag = wm_crc;
            end
        join
        wait (cap_n >= base + exp_n);
        for (int j = 0; j < exp_n; j++) begin
            string req;
            if (j == 0 || j <= HDR_WORDS) req = "R3 start/header";
            else if (j == exp_n - 2)      req = "R6 end control";
            else if (j == exp_n - 1)      req = "R7 crc word";
            else if (j - HDR_WORDS - 1 < (len + 3) / 4) req = "R4 payload";
            else                          req = "R5 pad";
            check({req, " ctrl flag"}, {31'd0, cap_ctrl[base + j]}, {31'd0, exp_ctrl[j]});
            check(req, cap_data[base + j], exp_data[j]);
        end
        if (check_gap && prev_crc_cyc >= 0) begin
            check("R8 start spacing", cap_cyc[base] - prev_crc_cyc,
                  prev_wm ? T_CYC + 2 : 2);
            check("R9 clear pulses", clr_cnt - clr_mark, (prev_wm && prev_late) ? 1 : 0);
        end
        prev_crc_cyc = cap_cyc[base + exp_n - 1];
        prev_wm      = wm_crc;
        prev_late    = wm_late;
        @(negedge clk);
        wm_flag  = wm_late;
        clr_mark = clr_cnt;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 wr_en", {31'd0, wr_en}, 32'd0);
        check("R1 in_ready", {31'd0, in_ready}, 32'd0);
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 wm_clr", {31'd0, wm_clr}, 32'd0);

        $urandom(32'h5eed1234);

        // Directed lengths around word and minimum-size boundaries
        run_frame(60, 0, 0, 0, 0);
        run_frame(1,  0, 0, 0, 1);
        run_frame(4,  0, 0, 0, 1);
        run_frame(59, 0, 0, 0, 1);
        run_frame(61, 0, 0, 0, 1);
        run_frame(63, 0, 0, 0, 1);
        run_frame(64, 0, 0, 0, 1);
        run_frame(100, 0, 0, 1, 1);

        // R2 refused frame: busy, no byte taken, no write
        begin
            int base;
            repeat (4) @(negedge clk);
            base = cap_n;
            q_ready  = 1'b0;
            in_valid = 1'b1;
            in_first = 1'b1;
            in_data  = 8'hA5;
            in_len   = LEN_W'(20);
            #1;
            check("R2 busy", {31'd0, busy}, 32'd1);
            check("R2 in_ready", {31'd0, in_ready}, 32'd0);
            repeat (4) @(negedge clk);
            check("R2 no writes", cap_n - base, 0);
            in_valid = 1'b0;
            in_first = 1'b0;
            q_ready  = 1'b1;
            @(negedge clk);
            prev_crc_cyc = -1;
        end

        // R8/R9 watermark hold-off with and without a clear at expiry
        run_frame(70, 1, 1, 0, 0);
        run_frame(20, 0, 0, 0, 1);
        run_frame(30, 1, 0, 1, 1);
        run_frame(45, 0, 0, 0, 1);
        run_frame(8,  0, 0, 0, 1);

        // Random lengths with random byte-stream gaps (R10)
        for (int r = 0; r < 12; r++)
            run_frame(1 + int'($urandom % 200), 0, 0, bit'($urandom % 2), 1);

        repeat (5) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            summary();
            $finish;
        end
    end

endmodule